// File: doc/BRIEF.md
# Segment Base Override Address Unit

This block keeps the two segment base registers that remain meaningful when a core runs in 64-bit mode. The first is the FS base and the second is the GS base. For every memory operand it forms the effective address from four terms: a base register, a scaled index, a sign-extended displacement and, only when an FS or GS override is present, the matching segment base. Every other override selector contributes nothing to the sum. The sum wraps freely across the whole address space.

Each base can be written through two paths, and each path has its own permission rules. The model-specific register port is privileged. It is addressed by a 32-bit register number and also allows reads. The base-write instruction port works at any privilege level, but only while a control enable bit is set and the core is in 64-bit mode. A rejected access never changes a base. Instead it raises a combinational fault flag in the same cycle as the request.

Top module: `seg_base_agu`

## Requirements
- R1: When `seg_sel` is FS (5) or GS (6) and `mode64` is 1, `ea` equals the selected base plus `addr_base` plus the scaled index plus the displacement, taken modulo 2^64. A sum that crosses from the top of the address space into low addresses wraps without any fault.
- R2: Override codes none (0), ES (1), CS (2), SS (3) and DS (4) add no segment base. FS and GS also add no base while `mode64` is 0.
- R3: `addr_scale` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. `addr_disp` is a signed 32-bit value that is sign-extended before the add.
- R4: After reset both bases are zero.
- R5: At `cpl`=0, a register-port write (`msr_we`=1) of a canonical value to address C000_0100h loads the FS base, and to C000_0101h loads the GS base. The new value appears in `ea` one cycle later. A read (`msr_we`=0) of either address returns that base on `msr_rdata` in the same cycle.
- R6: A register-port access at a nonzero `cpl` raises `fault`, returns zero and leaves both bases unchanged.
- R7: A register-port write whose bits 63:48 are not all equal to bit 47 raises `fault` and leaves both bases unchanged.
- R8: A register-port access to any other address raises `fault`, returns zero and changes no base.
- R9: An instruction-port write (`ins_gs` 0 targets FS, 1 targets GS) is accepted at any `cpl` when `base_en`=1 and `mode64`=1. Otherwise it raises `fault` and the base stays unchanged.
- R10: An accepted instruction-port write with `ins_op32`=1 loads the low 32 bits of `ins_data` and clears bits 63:32 of the target base.
- R11: An instruction-port write with `ins_op32`=0 and a non-canonical `ins_data` raises `fault` and leaves the base unchanged.
- R12: When both ports make accepted writes to the same base in the same cycle, the register-port value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | Core is in 64-bit mode |
| cpl | input | 2 | Current privilege level |
| base_en | input | 1 | Control bit that enables the instruction write port |
| seg_sel | input | 3 | Override: 0 none, 1 ES, 2 CS, 3 SS, 4 DS, 5 FS, 6 GS |
| addr_base | input | 64 | Base register operand |
| addr_index | input | 64 | Index register operand |
| addr_scale | input | 2 | Index scale code (log2 of the factor) |
| addr_disp | input | 32 | Signed displacement |
| ea | output | 64 | Effective address |
| msr_req | input | 1 | Register-port access request |
| msr_we | input | 1 | 1 write, 0 read |
| msr_addr | input | 32 | Register number |
| msr_wdata | input | 64 | Register write data |
| msr_rdata | output | 64 | Register read data (zero unless the read is accepted) |
| ins_req | input | 1 | Instruction-port write request |
| ins_gs | input | 1 | Target: 0 FS base, 1 GS base |
| ins_op32 | input | 1 | 32-bit operand size |
| ins_data | input | 64 | Instruction source operand |
| fault | output | 1 | A request in this cycle was rejected |

## Verification
The hardest case to reach is two accepted writes that land on the same base in one cycle. The bench holds the register-port request and the instruction-port request together across a single clock edge, so both arrive at once. It then reads the base back in the next cycle. Wraparound of the effective address is reached by loading a base just below 2^64 and adding a positive base register. A rejected write is confirmed only by reading the base back at privilege 0 afterwards, because a fault on its own does not show whether the base was left unchanged.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
   typedef enum logic [2:0] {
      SEG_NONE = 3'd0,
      SEG_ES   = 3'd1,
      SEG_CS   = 3'd2,
      SEG_SS   = 3'd3,
      SEG_DS   = 3'd4,
      SEG_FS   = 3'd5,
      SEG_GS   = 3'd6
   } seg_sel_e;

   localparam int unsigned NUM_BASES = 2;
   localparam int unsigned IDX_FS    = 0;
   localparam int unsigned IDX_GS    = 1;
endpackage

// File: rtl/seg_canon_chk.sv
module seg_canon_chk #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned VA_BITS = 48
) (
   input  logic [ADDR_W-1:0] value,
   output logic              ok
);
   localparam int unsigned TOP_W = ADDR_W - VA_BITS + 1;

   initial begin
      assert (VA_BITS < ADDR_W && VA_BITS > 1)
         else $fatal(1, "seg_canon_chk: VA_BITS must lie below ADDR_W");
   end

   logic [TOP_W-1:0] top_bits;
   assign top_bits = value[ADDR_W-1:VA_BITS-1];
   assign ok       = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/seg_ea_adder.sv
module seg_ea_adder
   import seg_base_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DISP_W = 32
) (
   input  logic              mode64,
   input  logic [2:0]        seg_sel,
   input  logic [ADDR_W-1:0] fs_base,
   input  logic [ADDR_W-1:0] gs_base,
   input  logic [ADDR_W-1:0] addr_base,
   input  logic [ADDR_W-1:0] addr_index,
   input  logic [1:0]        addr_scale,
   input  logic [DISP_W-1:0] addr_disp,
   output logic [ADDR_W-1:0] ea
);
   localparam int unsigned EXT_W = ADDR_W - DISP_W;

   initial begin
      assert (DISP_W < ADDR_W)
         else $fatal(1, "seg_ea_adder: DISP_W must be narrower than ADDR_W");
   end

   seg_sel_e          sel;
   logic [ADDR_W-1:0] seg_term;
   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] disp_term;

   assign sel = seg_sel_e'(seg_sel);

   always_comb begin
      seg_term = '0;
      if (mode64) begin
         if (sel == SEG_FS)      seg_term = fs_base;
         else if (sel == SEG_GS) seg_term = gs_base;
      end
   end

   assign idx_term  = addr_index << addr_scale;
   assign disp_term = {{EXT_W{addr_disp[DISP_W-1]}}, addr_disp};
   assign ea        = seg_term + addr_base + idx_term + disp_term;
endmodule

// File: rtl/seg_base_regs.sv
module seg_base_regs
   import seg_base_pkg::*;
#(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned VA_BITS = 48,
   parameter int unsigned MSR_W   = 32,
   parameter logic [MSR_W-1:0] FS_ADDR = 32'hC000_0100,
   parameter logic [MSR_W-1:0] GS_ADDR = 32'hC000_0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode64,
   input  logic [1:0]        cpl,
   input  logic              base_en,
   input  logic              msr_req,
   input  logic              msr_we,
   input  logic [MSR_W-1:0]  msr_addr,
   input  logic [ADDR_W-1:0] msr_wdata,
   output logic [ADDR_W-1:0] msr_rdata,
   input  logic              ins_req,
   input  logic              ins_gs,
   input  logic              ins_op32,
   input  logic [ADDR_W-1:0] ins_data,
   output logic [ADDR_W-1:0] fs_base,
   output logic [ADDR_W-1:0] gs_base,
   output logic              fault
);
   localparam int unsigned HALF_W = ADDR_W / 2;

   initial begin
      assert (ADDR_W % 2 == 0 && FS_ADDR != GS_ADDR)
         else $fatal(1, "seg_base_regs: bad parameters");
   end

   logic [ADDR_W-1:0]    base_q [NUM_BASES];
   logic [NUM_BASES-1:0] msr_hit;
   logic [NUM_BASES-1:0] msr_wr;
   logic [NUM_BASES-1:0] ins_wr;
   logic                 msr_canon;
   logic                 ins_canon;
   logic                 msr_priv;
   logic                 ins_allowed;
   logic                 msr_fault;
   logic                 ins_fault;
   logic [ADDR_W-1:0]    ins_val;

   seg_canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_msr_canon (
      .value (msr_wdata),
      .ok    (msr_canon)
   );

   seg_canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_ins_canon (
      .value (ins_data),
      .ok    (ins_canon)
   );

   assign msr_hit[IDX_FS] = (msr_addr == FS_ADDR);
   assign msr_hit[IDX_GS] = (msr_addr == GS_ADDR);
   assign msr_priv        = (cpl == 2'd0);

   assign msr_fault   = msr_req & (~msr_priv | ~(|msr_hit) | (msr_we & ~msr_canon));
   assign ins_allowed = base_en & mode64 & (ins_op32 | ins_canon);
   assign ins_fault   = ins_req & ~ins_allowed;
   assign fault       = msr_fault | ins_fault;

   assign ins_val = ins_op32 ? {{HALF_W{1'b0}}, ins_data[HALF_W-1:0]} : ins_data;

   for (genvar gi = 0; gi < NUM_BASES; gi++) begin : g_base
      assign msr_wr[gi] = msr_req & msr_we & msr_priv & msr_canon & msr_hit[gi];
      assign ins_wr[gi] = ins_req & ins_allowed & (ins_gs == gi[0]);

      always_ff @(posedge clk) begin
         if (!rst_n)          base_q[gi] <= '0;
         else if (msr_wr[gi]) base_q[gi] <= msr_wdata;
         else if (ins_wr[gi]) base_q[gi] <= ins_val;
      end
   end

   always_comb begin
      msr_rdata = '0;
      if (msr_req && !msr_we && msr_priv) begin
         if (msr_hit[IDX_FS])      msr_rdata = base_q[IDX_FS];
         else if (msr_hit[IDX_GS]) msr_rdata = base_q[IDX_GS];
      end
   end

   assign fs_base = base_q[IDX_FS];
   assign gs_base = base_q[IDX_GS];

   // R5: privileged canonical write lands in the FS base one cycle later
   assert_fs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_req && msr_we && cpl == 2'd0 && msr_addr == FS_ADDR && msr_canon)
      |=> (fs_base == $past(msr_wdata)));

   assert_priv_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_req && cpl != 2'd0) |-> (fault && msr_rdata == '0));

   assert_priv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_req && msr_we && cpl != 2'd0 && !ins_req)
      |=> ($stable(fs_base) && $stable(gs_base)));

   assert_noncanon_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_req && msr_we && !ins_req &&
       !(&msr_wdata[ADDR_W-1:VA_BITS-1]) && (|msr_wdata[ADDR_W-1:VA_BITS-1]))
      |=> ($stable(fs_base) && $stable(gs_base)));

   assert_bad_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_req && msr_addr != FS_ADDR && msr_addr != GS_ADDR)
      |-> (fault && msr_rdata == '0));

   assert_op32_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && ins_op32 && base_en && mode64 && !msr_req)
      |=> (($past(ins_gs) ? gs_base[ADDR_W-1:HALF_W] : fs_base[ADDR_W-1:HALF_W]) == '0));
endmodule

// File: rtl/seg_base_agu.sv
module seg_base_agu #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned VA_BITS = 48,
   parameter int unsigned DISP_W  = 32,
   parameter int unsigned MSR_W   = 32,
   parameter logic [MSR_W-1:0] FS_ADDR = 32'hC000_0100,
   parameter logic [MSR_W-1:0] GS_ADDR = 32'hC000_0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode64,
   input  logic [1:0]        cpl,
   input  logic              base_en,
   input  logic [2:0]        seg_sel,
   input  logic [ADDR_W-1:0] addr_base,
   input  logic [ADDR_W-1:0] addr_index,
   input  logic [1:0]        addr_scale,
   input  logic [DISP_W-1:0] addr_disp,
   output logic [ADDR_W-1:0] ea,
   input  logic              msr_req,
   input  logic              msr_we,
   input  logic [MSR_W-1:0]  msr_addr,
   input  logic [ADDR_W-1:0] msr_wdata,
   output logic [ADDR_W-1:0] msr_rdata,
   input  logic              ins_req,
   input  logic              ins_gs,
   input  logic              ins_op32,
   input  logic [ADDR_W-1:0] ins_data,
   output logic              fault
);
   logic [ADDR_W-1:0] fs_base;
   logic [ADDR_W-1:0] gs_base;

   seg_base_regs #(
      .ADDR_W  (ADDR_W),
      .VA_BITS (VA_BITS),
      .MSR_W   (MSR_W),
      .FS_ADDR (FS_ADDR),
      .GS_ADDR (GS_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode64    (mode64),
      .cpl       (cpl),
      .base_en   (base_en),
      .msr_req   (msr_req),
      .msr_we    (msr_we),
      .msr_addr  (msr_addr),
      .msr_wdata (msr_wdata),
      .msr_rdata (msr_rdata),
      .ins_req   (ins_req),
      .ins_gs    (ins_gs),
      .ins_op32  (ins_op32),
      .ins_data  (ins_data),
      .fs_base   (fs_base),
      .gs_base   (gs_base),
      .fault     (fault)
   );

   seg_ea_adder #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_adder (
      .mode64     (mode64),
      .seg_sel    (seg_sel),
      .fs_base    (fs_base),
      .gs_base    (gs_base),
      .addr_base  (addr_base),
      .addr_index (addr_index),
      .addr_scale (addr_scale),
      .addr_disp  (addr_disp),
      .ea         (ea)
   );
endmodule

// File: tb/test_seg_base_agu.sv
`timescale 1ns/1ps
module test_seg_base_agu;
   localparam logic [31:0] A_FS = 32'hC000_0100;
   localparam logic [31:0] A_GS = 32'hC000_0101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64 = 1'b1;
   logic [1:0]  cpl = 2'd0;
   logic        base_en = 1'b1;
   logic [2:0]  seg_sel = 3'd0;
   logic [63:0] addr_base = '0;
   logic [63:0] addr_index = '0;
   logic [1:0]  addr_scale = '0;
   logic [31:0] addr_disp = '0;
   logic [63:0] ea;
   logic        msr_req = 1'b0;
   logic        msr_we = 1'b0;
   logic [31:0] msr_addr = '0;
   logic [63:0] msr_wdata = '0;
   logic [63:0] msr_rdata;
   logic        ins_req = 1'b0;
   logic        ins_gs = 1'b0;
   logic        ins_op32 = 1'b0;
   logic [63:0] ins_data = '0;
   logic        fault;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   seg_base_agu i_seg_base_agu (
      .clk(clk), .rst_n(rst_n), .mode64(mode64), .cpl(cpl), .base_en(base_en),
      .seg_sel(seg_sel), .addr_base(addr_base), .addr_index(addr_index),
      .addr_scale(addr_scale), .addr_disp(addr_disp), .ea(ea),
      .msr_req(msr_req), .msr_we(msr_we), .msr_addr(msr_addr),
      .msr_wdata(msr_wdata), .msr_rdata(msr_rdata),
      .ins_req(ins_req), .ins_gs(ins_gs), .ins_op32(ins_op32),
      .ins_data(ins_data), .fault(fault)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ea_model(input logic [63:0] sb, input logic [63:0] b,
                                            input logic [63:0] i, input logic [1:0] s,
                                            input logic [31:0] d);
      return sb + b + (i * (64'd1 << s)) + {{32{d[31]}}, d};
   endfunction

   task automatic ea_case(input string tag, input logic [2:0] sel, input logic [63:0] b,
                          input logic [63:0] i, input logic [1:0] s, input logic [31:0] d,
                          input logic [63:0] exp);
      @(negedge clk);
      seg_sel = sel; addr_base = b; addr_index = i; addr_scale = s; addr_disp = d;
      #1 check(tag, ea, exp);
   endtask

   task automatic msr_op(input string tag, input logic we, input logic [31:0] a,
                         input logic [63:0] wd, input logic [1:0] lvl,
                         input logic exp_fault, input logic [63:0] exp_rd);
      @(negedge clk);
      msr_req = 1'b1; msr_we = we; msr_addr = a; msr_wdata = wd; cpl = lvl;
      #1;
      check({tag, " fault"}, {63'd0, fault}, {63'd0, exp_fault});
      if (!we) check({tag, " rdata"}, msr_rdata, exp_rd);
      @(negedge clk);
      msr_req = 1'b0; cpl = 2'd0;
   endtask

   task automatic ins_op(input string tag, input logic gs, input logic op32,
                         input logic [63:0] d, input logic [1:0] lvl, input logic exp_fault);
      @(negedge clk);
      ins_req = 1'b1; ins_gs = gs; ins_op32 = op32; ins_data = d; cpl = lvl;
      #1 check({tag, " fault"}, {63'd0, fault}, {63'd0, exp_fault});
      @(negedge clk);
      ins_req = 1'b0; cpl = 2'd0;
   endtask

   task automatic read_fs(input string tag, input logic [63:0] exp);
      msr_op(tag, 1'b0, A_FS, '0, 2'd0, 1'b0, exp);
   endtask

   task automatic read_gs(input string tag, input logic [63:0] exp);
      msr_op(tag, 1'b0, A_GS, '0, 2'd0, 1'b0, exp);
   endtask

   task automatic t_reset;
      read_fs("R4 fs after reset", 64'd0);
      read_gs("R4 gs after reset", 64'd0);
      ea_case("R4 ea with zero fs", 3'd5, 64'h1000, 64'h0, 2'd0, 32'h0, 64'h1000);
   endtask

   task automatic t_msr_load;
      msr_op("R5 write fs", 1'b1, A_FS, 64'h0000_7FFF_0000_1000, 2'd0, 1'b0, '0);
      msr_op("R5 write gs", 1'b1, A_GS, 64'hFFFF_8000_0000_0000, 2'd0, 1'b0, '0);
      read_fs("R5 read fs", 64'h0000_7FFF_0000_1000);
      read_gs("R5 read gs", 64'hFFFF_8000_0000_0000);
      ea_case("R1 fs ea", 3'd5, 64'h20, 64'h3, 2'd0, 32'h4,
              ea_model(64'h0000_7FFF_0000_1000, 64'h20, 64'h3, 2'd0, 32'h4));
      ea_case("R1 gs ea", 3'd6, 64'h100, 64'h10, 2'd1, 32'h8,
              ea_model(64'hFFFF_8000_0000_0000, 64'h100, 64'h10, 2'd1, 32'h8));
   endtask

   task automatic t_scale_disp;
      for (int s = 0; s < 4; s++)
         ea_case("R3 scale", 3'd0, 64'h1000, 64'h7, s[1:0], 32'h0, 64'h1000 + 64'h7 * (64'd1 << s));
      ea_case("R3 negative disp", 3'd0, 64'h1000, 64'h0, 2'd0, 32'hFFFF_FFF0, 64'h0FF0);
   endtask

   task automatic t_no_base;
      for (int sel = 0; sel < 5; sel++)
         ea_case("R2 non-fs/gs sel", sel[2:0], 64'h500, 64'h2, 2'd2, 32'h1, 64'h509);
      @(negedge clk) mode64 = 1'b0;
      ea_case("R2 fs outside 64-bit mode", 3'd5, 64'h500, 64'h0, 2'd0, 32'h0, 64'h500);
      @(negedge clk) mode64 = 1'b1;
   endtask

   task automatic t_priv;
      msr_op("R6 cpl3 write", 1'b1, A_FS, 64'h1234, 2'd3, 1'b1, '0);
      msr_op("R6 cpl1 read", 1'b0, A_GS, '0, 2'd1, 1'b1, 64'd0);
      read_fs("R6 fs unchanged", 64'h0000_7FFF_0000_1000);
   endtask

   task automatic t_noncanon;
      msr_op("R7 noncanon write", 1'b1, A_GS, 64'h0001_0000_0000_0000, 2'd0, 1'b1, '0);
      read_gs("R7 gs unchanged", 64'hFFFF_8000_0000_0000);
   endtask

   task automatic t_bad_addr;
      msr_op("R8 bad read", 1'b0, 32'hC000_0102, '0, 2'd0, 1'b1, 64'd0);
      msr_op("R8 bad write", 1'b1, 32'h0000_0100, 64'h55, 2'd0, 1'b1, '0);
      read_fs("R8 fs unchanged", 64'h0000_7FFF_0000_1000);
      read_gs("R8 gs unchanged", 64'hFFFF_8000_0000_0000);
   endtask

   task automatic t_ins;
      @(negedge clk) base_en = 1'b0;
      ins_op("R9 disabled", 1'b0, 1'b0, 64'h42, 2'd3, 1'b1);
      @(negedge clk) begin base_en = 1'b1; mode64 = 1'b0; end
      ins_op("R9 not 64-bit", 1'b0, 1'b0, 64'h42, 2'd3, 1'b1);
      @(negedge clk) mode64 = 1'b1;
      read_fs("R9 fs unchanged", 64'h0000_7FFF_0000_1000);
      ins_op("R9 cpl3 allowed", 1'b0, 1'b0, 64'h0000_0000_ABCD_0000, 2'd3, 1'b0);
      read_fs("R9 fs loaded", 64'h0000_0000_ABCD_0000);
      ins_op("R10 op32", 1'b1, 1'b1, 64'hDEAD_BEEF_1234_5678, 2'd3, 1'b0);
      read_gs("R10 upper cleared", 64'h0000_0000_1234_5678);
      ins_op("R11 noncanon op64", 1'b1, 1'b0, 64'h8000_0000_0000_0000, 2'd2, 1'b1);
      read_gs("R11 gs unchanged", 64'h0000_0000_1234_5678);
   endtask

   task automatic t_collide_wrap;
      @(negedge clk);
      msr_req = 1'b1; msr_we = 1'b1; msr_addr = A_GS; msr_wdata = 64'hFFFF_FFFF_FFFF_F000;
      ins_req = 1'b1; ins_gs = 1'b1; ins_op32 = 1'b0; ins_data = 64'h0000_0000_0000_7777;
      #1 check("R12 both ports fault", {63'd0, fault}, 64'd0);
      @(negedge clk);
      msr_req = 1'b0; ins_req = 1'b0;
      read_gs("R12 register port wins", 64'hFFFF_FFFF_FFFF_F000);
      ea_case("R1 wrap", 3'd6, 64'h2000, 64'h0, 2'd0, 32'h0, 64'h1000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_msr_load();
      t_scale_disp();
      t_no_base();
      t_priv();
      t_noncanon();
      t_bad_addr();
      t_ins();
      t_collide_wrap();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule